// File: doc/BRIEF.md
# Peripheral Register Field Access Unit

This unit carries out the two coprocessor instructions that reach the registers of three small on-chip peripheral banks: a control bank, an I/O bank and a converter bank. A sequencer presents a 32-bit instruction word together with a one-cycle start strobe. The unit decodes the word and checks it. It then drives a simple synchronous register bus and signals completion with a one-cycle done pulse. Malformed words also end with that pulse, and they raise an error flag with it.

The field-read instruction takes the bits from a high index down to a low index of the addressed register. It loads them, right-aligned, into the 16-bit general register R0. The field-write instruction performs a read-modify-write. It reads the register and replaces only the bits in the high:low range with an 8-bit literal. It then writes the whole word back, so every other bit keeps its old value.

The control sequence is a four-state machine:
- IDLE waits for start. On a valid word it moves to REQ. On an invalid word it stays in IDLE and finishes with an error.
- REQ holds the one-cycle bus read request and always moves to WAIT.
- WAIT captures the read data. A read loads R0 and returns to IDLE. A write computes the merged word and moves to WRITE.
- WRITE holds the one-cycle bus write and returns to IDLE.

Top module: `pfa_unit`

## Requirements
- R1: The instruction fields are: address at [7:0], bank select at [9:8], literal at [17:10], low index at [22:18], high index at [27:23] and opcode at [31:28]. During the bus read and the bus write, `bus_addr` equals the address field and `bus_bank` equals the select field. Bank 0 is control, 1 is I/O and 2 is converter.
- R2: Opcode 2 (field read) sets R0 to register bits high..low, right-aligned, with zeros above the field. It issues exactly one bus read and no bus write.
- R3: For a field read, a field wider than 16 bits is truncated to its low 16 bits in R0.
- R4: Opcode 1 (field write, a parameter) issues one bus read and then one bus write to the same bank and address. The written word has the literal in bits high..low and the register's old value in every other bit.
- R5: For a field write, a field wider than 8 bits receives the literal zero-extended, so the field bits above the literal are cleared.
- R6: For a field read, the literal field is ignored: any literal gives the same R0.
- R7: A word with select 3, high < low, or an opcode other than 1 or 2 makes no bus access and leaves R0 unchanged. It asserts `err` together with `done`. `err` is never high without `done`.
- R8: Count the rising edge that samples start as edge 0. `done` is high after edge 0 for an invalid word, after edge 2 for a read and after edge 3 for a write.
- R9: `done` lasts one cycle. A start that arrives while an instruction is in progress is ignored.
- R10: After reset, `r0`, `done`, `err`, `bus_rd` and `bus_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe; the instruction word is taken when the unit is idle |
| instr | input | 32 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with done when the word was rejected |
| r0 | output | 16 | General register R0 |
| bus_rd | output | 1 | Registered bus read request |
| bus_we | output | 1 | Registered bus write enable |
| bus_bank | output | 2 | Registered bank select |
| bus_addr | output | 8 | Registered register address |
| bus_wdata | output | 32 | Registered write data |
| bus_rdata | input | 32 | Read data, valid in the cycle after the one in which bus_rd is high |

## Verification
The assertions assume that the bus returns the addressed word in the cycle right after the request and holds it there. They assume `start` is never unknown once reset is released, and that no other master changes a register between the read and the write-back of one instruction. The bench peripheral model registers its read data on the clock edge that samples `bus_rd`, and it is the only agent that writes its bank memories. The bench holds `start` low whenever it has no word to issue, except in the deliberate busy-start case, where the extra strobes fall only in cycles when the unit is not idle.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    // Instruction word layout, most significant field first.
    typedef struct packed {
        logic [3:0] op;
        logic [4:0] hi;
        logic [4:0] lo;
        logic [7:0] lit;
        logic [1:0] sel;
        logic [7:0] addr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } state_t;

endpackage

// File: rtl/pfa_decode.sv
module pfa_decode #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3,
    parameter int OP_RD     = 2,
    parameter int OP_WR     = 1,
    localparam int IDX_W    = $clog2(DATA_W)
) (
    input  logic [3:0]        op,
    input  logic [IDX_W-1:0]  hi,
    input  logic [IDX_W-1:0]  lo,
    input  logic [1:0]        sel,
    output logic              ok,
    output logic              is_wr,
    output logic [DATA_W-1:0] mask
);
    logic bank_ok;
    logic range_ok;
    logic op_ok;

    assign bank_ok  = int'(sel) < NUM_BANKS;
    assign range_ok = hi >= lo;
    assign is_wr    = op == 4'(OP_WR);
    assign op_ok    = is_wr || (op == 4'(OP_RD));
    assign ok       = bank_ok && range_ok && op_ok;

    // One comparator pair per bit builds the contiguous field mask.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        localparam logic [IDX_W:0] POS = (IDX_W+1)'(i);
        assign mask[i] = (POS >= {1'b0, lo}) && (POS <= {1'b0, hi});
    end

endmodule

// File: rtl/pfa_field.sv
module pfa_field #(
    parameter int DATA_W = 32,
    parameter int R0_W   = 16,
    parameter int LIT_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] mask,
    input  logic [IDX_W-1:0]  lo,
    input  logic [LIT_W-1:0]  lit,
    output logic [R0_W-1:0]   field,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] lit_sh;

    assign masked = rdata & mask;
    assign field  = R0_W'(masked >> lo);
    assign lit_sh = {{(DATA_W-LIT_W){1'b0}}, lit} << lo;

    for (genvar i = 0; i < DATA_W; i++) begin : g_merge
        assign merged[i] = mask[i] ? lit_sh[i] : rdata[i];
    end

endmodule

// File: rtl/pfa_fsm.sv
module pfa_fsm
    import pfa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int R0_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ok,
    input  logic              is_wr,
    input  logic [R0_W-1:0]   field,
    input  logic [DATA_W-1:0] merged,
    output logic              idle,
    output logic              done,
    output logic              err,
    output logic [R0_W-1:0]   r0,
    output logic              bus_rd,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata
);
    state_t state;
    state_t state_nx;

    assign idle = state == ST_IDLE;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start && ok) state_nx = ST_REQ;
            ST_REQ:   state_nx = ST_WAIT;
            ST_WAIT:  state_nx = is_wr ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            r0        <= '0;
            bus_rd    <= 1'b0;
            bus_we    <= 1'b0;
            bus_wdata <= '0;
        end else begin
            done   <= 1'b0;
            err    <= 1'b0;
            bus_rd <= 1'b0;
            bus_we <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        bus_rd <= ok;
                        done   <= !ok;
                        err    <= !ok;
                    end
                end
                ST_REQ: begin
                end
                ST_WAIT: begin
                    if (is_wr) begin
                        bus_we    <= 1'b1;
                        bus_wdata <= merged;
                    end else begin
                        r0   <= field;
                        done <= 1'b1;
                    end
                end
                ST_WRITE: done <= 1'b1;
                default: begin
                end
            endcase
        end
    end

    assert_no_rd_we_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_we));

    assert_we_follows_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $past(bus_rd, 2));

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_err_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_rd && !bus_we));

    assert_err_keeps_r0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(r0));

endmodule

// File: rtl/pfa_unit.sv
module pfa_unit
    import pfa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int R0_W      = 16,
    parameter int NUM_BANKS = 3,
    parameter int OP_RD     = 2,
    parameter int OP_WR     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    output logic              done,
    output logic              err,
    output logic [R0_W-1:0]   r0,
    output logic              bus_rd,
    output logic              bus_we,
    output logic [1:0]        bus_bank,
    output logic [7:0]        bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int LIT_W = 8;

    instr_t            held;
    instr_t            dec_src;
    logic              idle;
    logic              ok;
    logic              is_wr;
    logic [DATA_W-1:0] mask;
    logic [R0_W-1:0]   field;
    logic [DATA_W-1:0] merged;

    // Capture the word when it is accepted; it then drives the bus fields.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             held <= '0;
        else if (idle && start) held <= instr_t'(instr);
    end

    assign dec_src  = idle ? instr_t'(instr) : held;
    assign bus_bank = held.sel;
    assign bus_addr = held.addr;

    pfa_decode #(
        .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .OP_RD(OP_RD), .OP_WR(OP_WR)
    ) u_decode (
        .op(dec_src.op), .hi(dec_src.hi), .lo(dec_src.lo), .sel(dec_src.sel),
        .ok(ok), .is_wr(is_wr), .mask(mask)
    );

    pfa_field #(
        .DATA_W(DATA_W), .R0_W(R0_W), .LIT_W(LIT_W)
    ) u_field (
        .rdata(bus_rdata), .mask(mask), .lo(held.lo), .lit(held.lit),
        .field(field), .merged(merged)
    );

    pfa_fsm #(
        .DATA_W(DATA_W), .R0_W(R0_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ok(ok), .is_wr(is_wr),
        .field(field), .merged(merged), .idle(idle), .done(done), .err(err),
        .r0(r0), .bus_rd(bus_rd), .bus_we(bus_we), .bus_wdata(bus_wdata)
    );

    assert_merge_keeps_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (((bus_wdata ^ $past(bus_rdata)) & ~mask) == '0));

    assert_write_same_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ($stable(bus_addr) && $stable(bus_bank)));

endmodule

// File: tb/pfa_unit_tb.sv
module pfa_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        done, err, bus_rd, bus_we;
    logic [15:0] r0;
    logic [1:0]  bus_bank;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int compared = 0;
    int mismatched = 0;
    int rd_cnt = 0;
    int we_cnt = 0;
    logic [1:0] rd_bank, we_bank;
    logic [7:0] rd_addr, we_addr;
    logic [31:0] mem [3][256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfa_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .done(done), .err(err), .r0(r0), .bus_rd(bus_rd), .bus_we(bus_we),
        .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Peripheral model: registered read data, write on the enable edge.
    always @(posedge clk) begin
        if (bus_rd && bus_bank != 2'd3) begin
            bus_rdata <= mem[bus_bank][bus_addr];
            rd_cnt    <= rd_cnt + 1;
            rd_bank   <= bus_bank;
            rd_addr   <= bus_addr;
        end
        if (bus_we && bus_bank != 2'd3) begin
            mem[bus_bank][bus_addr] <= bus_wdata;
            we_cnt  <= we_cnt + 1;
            we_bank <= bus_bank;
            we_addr <= bus_addr;
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [4:0] hi,
                                        input logic [4:0] lo, input logic [7:0] lit,
                                        input logic [1:0] sel, input logic [7:0] addr);
        return {op, hi, lo, lit, sel, addr};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    int lat;
    logic got_err;

    // Issue one word; measure edges from the start edge until done.
    task automatic run(input logic [31:0] w);
        lat = -1;
        start = 1'b1;
        instr = w;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 8; n++) begin
            if (n > 0) @(negedge clk);
            if (done) begin
                lat = n;
                got_err = err;
                break;
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    endtask

    // Read vectors: {instr fields, expected r0}.
    localparam int NV = 8;
    localparam logic [47:0] RD_VEC [NV] = '{
        {4'd2, 5'd7,  5'd0,  8'h00, 2'd0, 8'h10, 16'h000F},
        {4'd2, 5'd15, 5'd8,  8'h00, 2'd0, 8'h10, 16'h00F0},
        {4'd2, 5'd31, 5'd16, 8'h00, 2'd1, 8'h22, 16'h1234},
        {4'd2, 5'd31, 5'd0,  8'h00, 2'd2, 8'hFF, 16'hBEEF},
        {4'd2, 5'd31, 5'd31, 8'h00, 2'd2, 8'hFF, 16'h0001},
        {4'd2, 5'd0,  5'd0,  8'h00, 2'd1, 8'h22, 16'h0000},
        {4'd2, 5'd15, 5'd8,  8'hFF, 2'd1, 8'h22, 16'h0056},
        {4'd2, 5'd27, 5'd12, 8'h00, 2'd0, 8'h10, 16'h5C3F}
    };

    bit finished = 1'b0;

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int rc, wc;
        logic [15:0] r0_prev;
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < 256; a++) mem[b][a] = 32'h0;
        mem[0][8'h10] = 32'hA5C3_F00F;
        mem[1][8'h22] = 32'h1234_5678;
        mem[2][8'hFF] = 32'hDEAD_BEEF;

        repeat (3) @(negedge clk);
        check(r0 == 16'h0 && !done && !err, "R10 reset r0/done/err", {r0, 14'd0, done, err}, 32'd0);
        check(!bus_rd && !bus_we, "R10 reset bus", {30'd0, bus_rd, bus_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of read vectors (R2, R3, R6, R8, R1).
        for (int v = 0; v < NV; v++) begin
            rc = rd_cnt;
            wc = we_cnt;
            run(RD_VEC[v][47:16]);
            check(lat == 2 && !got_err, $sformatf("R8 read latency v%0d", v), 32'(lat), 32'd2);
            check(r0 == RD_VEC[v][15:0], $sformatf("R2 R3 R6 read value v%0d", v), 32'(r0), 32'(RD_VEC[v][15:0]));
            check(rd_cnt == rc + 1 && we_cnt == wc, $sformatf("R2 one read no write v%0d", v),
                  32'(rd_cnt - rc), 32'd1);
            check(rd_bank == RD_VEC[v][25:24] && rd_addr == RD_VEC[v][23:16],
                  $sformatf("R1 bus target v%0d", v), {22'd0, rd_bank, rd_addr},
                  {22'd0, RD_VEC[v][25:24], RD_VEC[v][23:16]});
        end

        // R4: field write with neighbouring bits preserved.
        rc = rd_cnt; wc = we_cnt;
        run(enc(4'd1, 5'd11, 5'd4, 8'h5A, 2'd0, 8'h10));
        check(lat == 3 && !got_err, "R8 write latency", 32'(lat), 32'd3);
        check(mem[0][8'h10] == 32'hA5C3_F5AF, "R4 merged word", mem[0][8'h10], 32'hA5C3_F5AF);
        check(rd_cnt == rc + 1 && we_cnt == wc + 1, "R4 one read one write", 32'(we_cnt - wc), 32'd1);
        check(we_bank == 2'd0 && we_addr == 8'h10, "R1 R4 write target", {22'd0, we_bank, we_addr}, 32'h010);
        run(enc(4'd2, 5'd15, 5'd0, 8'h00, 2'd0, 8'h10));
        check(r0 == 16'hF5AF, "R4 readback", 32'(r0), 32'hF5AF);

        // R5: wide field, literal zero-extended.
        run(enc(4'd1, 5'd23, 5'd8, 8'hC3, 2'd1, 8'h22));
        check(mem[1][8'h22] == 32'h1200_C378, "R5 zero extend", mem[1][8'h22], 32'h1200_C378);
        run(enc(4'd1, 5'd31, 5'd0, 8'h7E, 2'd2, 8'hFF));
        check(mem[2][8'hFF] == 32'h0000_007E, "R5 full word", mem[2][8'hFF], 32'h0000_007E);

        // R7: rejected words.
        r0_prev = r0;
        rc = rd_cnt; wc = we_cnt;
        run(enc(4'd2, 5'd7, 5'd0, 8'h00, 2'd3, 8'h10));
        check(lat == 0 && got_err, "R7 R8 select 3 error", 32'(lat), 32'd0);
        check(r0 == r0_prev, "R7 r0 unchanged", 32'(r0), 32'(r0_prev));
        run(enc(4'd1, 5'd2, 5'd9, 8'hFF, 2'd0, 8'h10));
        check(lat == 0 && got_err, "R7 high below low", 32'(lat), 32'd0);
        check(mem[0][8'h10] == 32'hA5C3_F5AF, "R7 register untouched", mem[0][8'h10], 32'hA5C3_F5AF);
        run(enc(4'd5, 5'd7, 5'd0, 8'h00, 2'd0, 8'h10));
        check(lat == 0 && got_err, "R7 unknown opcode", 32'(lat), 32'd0);
        check(rd_cnt == rc && we_cnt == wc, "R7 no bus access", 32'(rd_cnt - rc), 32'd0);

        // R9: start while busy is ignored.
        rc = rd_cnt; wc = we_cnt;
        start = 1'b1;
        instr = enc(4'd2, 5'd15, 5'd0, 8'h00, 2'd1, 8'h22);
        @(negedge clk);
        instr = enc(4'd1, 5'd7, 5'd0, 8'hAA, 2'd2, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done && !err, "R9 first word completes", 32'(done), 32'd1);
        check(r0 == 16'hC378, "R9 first word result", 32'(r0), 32'hC378);
        repeat (4) @(negedge clk);
        check(rd_cnt == rc + 1 && we_cnt == wc, "R9 busy start ignored", 32'(we_cnt - wc), 32'd0);
        check(mem[2][8'hFF] == 32'h0000_007E, "R9 ignored write target", mem[2][8'hFF], 32'h0000_007E);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule